// File: doc/BRIEF.md
# Readout Protection Level Controller

This block keeps the device's persistent protection level and decides, access by access, whether the main flash or the protected SRAM region may be touched. Each access arrives with the boot source the device started from, whether it comes from user code or from the debug port, and its kind (read, program or erase). The block answers at once, in the same cycle, with a grant or a bus error. It also drives the four debug-side disable outputs: JTAG, the trace viewer, instruction trace and boundary scan.

The level is held in non-volatile storage as an 8-bit code word. Any two valid code words differ in at least four bits. After reset the block waits for the stored word to load. Until then, and whenever the loaded pattern is not a valid code, it applies the strictest level.

A change request names a target code. Raising the level, or naming the current level again, needs only a write handshake to storage. Lowering the level first runs the mandatory erases and holds every protected access off until they finish. The new level is committed only after the erases have been acknowledged and the storage write has been acknowledged. The top level cannot be left.

Top module: `rdp_ctrl`

## Requirements
- R1: Level codes are 0x3C (level 0), 0x5A (level 0.5), 0xC3 (level 1) and 0xA5 (level 2). `levelCode` always shows the committed level and is always one of these four codes.
- R2: From reset until `nvLoadValid` is seen, `levelCode` reads 0xA5. A loaded word that is not one of the four codes leaves the level at 0xA5. A valid loaded word becomes the level one cycle after `nvLoadValid`.
- R3: At level 0 and level 0.5 every access is granted, whatever the boot source and requester, provided `accType` is read (0), program (1) or erase (2). The reserved type 3 always gets a bus error.
- R4: At level 1 and level 2, an access gets a bus error if it comes from the debug port (`accDebug`=1) or if the boot source is not flash. Boot source encoding: 0 is flash, 1 is SRAM, 2 is the system bootloader, and 3 is treated as not flash.
- R5: At level 1 and level 2, a user-code access (`accDebug`=0) with boot source flash and a valid type is granted.
- R6: `jtagOff`, `traceViewOff`, `instrTraceOff` and `bscanOff` are 1 exactly when `levelCode` is 0xA5, including before the load.
- R7: At level 2, every change request is refused. `chgErr` pulses, no erase is requested and the level stays 0xA5.
- R8: A request whose target is not a valid code is refused with a one-cycle `chgErr` pulse, in the cycle after the request, and nothing else changes. A request made while a change is still in progress is refused in the same way.
- R9: Lowering from level 1 to level 0, or from level 0.5 to level 0, raises `eraseFlashFull`, `eraseSram` and `eraseBkp`. Each stays high until its own acknowledge arrives.
- R10: Lowering from level 1 to level 0.5 raises only `eraseFlashNs`, which stays high until `eraseFlashAck`.
- R11: Raising the level, or requesting the current level, requests no erase. It raises `nvWrReq` with `nvWrCode` equal to the target and commits on `nvWrAck`.
- R12: While a lowering is in progress, every access gets a bus error. `nvWrReq` rises only after all erase acknowledges have arrived. `levelCode` changes in the same cycle that `chgDone` pulses, after `nvWrAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| nvLoadValid | input | 1 | Stored level word is present on `nvLoadCode` |
| nvLoadCode | input | 8 | Stored level word read at start-up |
| nvWrReq | output | 1 | Request to write `nvWrCode` to storage |
| nvWrCode | output | 8 | Level code to be stored |
| nvWrAck | input | 1 | Storage write complete |
| chgReq | input | 1 | Level change request strobe |
| chgCode | input | 8 | Requested target level code |
| chgDone | output | 1 | One-cycle pulse when the new level is committed |
| chgErr | output | 1 | One-cycle pulse when a request is refused |
| bootSrc | input | 2 | Boot source: 0 flash, 1 SRAM, 2 system bootloader |
| accValid | input | 1 | An access to flash or protected SRAM is presented |
| accDebug | input | 1 | 1 when the access comes from the debug port |
| accType | input | 2 | 0 read, 1 program, 2 erase, 3 reserved |
| accGrant | output | 1 | Access allowed |
| accBusErr | output | 1 | Access refused with a bus error |
| eraseFlashFull | output | 1 | Full flash mass-erase request |
| eraseFlashNs | output | 1 | Non-secure flash erase request |
| eraseSram | output | 1 | Protected SRAM erase request |
| eraseBkp | output | 1 | Backup register erase request |
| eraseFlashAck | input | 1 | Flash erase (either kind) finished |
| eraseSramAck | input | 1 | Protected SRAM erase finished |
| eraseBkpAck | input | 1 | Backup register erase finished |
| levelCode | output | 8 | Committed level code |
| jtagOff | output | 1 | JTAG disable |
| traceViewOff | output | 1 | Trace viewer disable |
| instrTraceOff | output | 1 | Instruction trace disable |
| bscanOff | output | 1 | Boundary scan disable |

## Verification
The following are checked on every cycle: the level is always a valid code, the top level never changes once loaded, and debug accesses under the disable outputs are refused. Also checked each cycle: any access during an erase is refused, the two flash erase kinds never coincide, a storage write never overlaps an erase, and the level moves only at load or with `chgDone`. Which erases a given level pair actually selects, the exact grant pattern for every combination of boot source, requester and type at each level, and the fail-safe result for each of the 256 possible loaded words can only be shown by the bench's sweeps.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

  localparam int LVL_W   = 8;
  localparam int ERASE_N = 4;

  // erase request bit positions
  localparam int ER_FULL = 3;
  localparam int ER_NS   = 2;
  localparam int ER_SRAM = 1;
  localparam int ER_BKP  = 0;

  // code words, pairwise Hamming distance of at least four
  localparam logic [LVL_W-1:0] LVL0  = 8'h3C;
  localparam logic [LVL_W-1:0] LVL05 = 8'h5A;
  localparam logic [LVL_W-1:0] LVL1  = 8'hC3;
  localparam logic [LVL_W-1:0] LVL2  = 8'hA5;

  localparam logic [1:0] BOOT_FLASH = 2'd0;
  localparam logic [1:0] TYPE_RSVD  = 2'd3;

  typedef enum logic [1:0] {ST_LOAD, ST_IDLE, ST_ERASE, ST_WRITE} ctrlState_t;

  typedef struct packed {
    logic loadLevel;
    logic latchTarget;
    logic commitTarget;
    logic blockAccess;
  } ctrlStrobe_t;

  typedef struct packed {
    logic tgtValid;
    logic frozen;
    logic lowering;
    logic fullErase;
    logic partialErase;
  } dpStatus_t;

  function automatic logic isLevel(input logic [LVL_W-1:0] c);
    return (c == LVL0) || (c == LVL05) || (c == LVL1) || (c == LVL2);
  endfunction

  function automatic logic [1:0] levelRank(input logic [LVL_W-1:0] c);
    case (c)
      LVL0:    return 2'd0;
      LVL05:   return 2'd1;
      LVL1:    return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/rdp_datapath.sv
module rdp_datapath
  import rdp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [LVL_W-1:0] nvLoadCode,
  input  logic [LVL_W-1:0] chgCode,
  input  logic [1:0]       bootSrc,
  input  logic             accValid,
  input  logic             accDebug,
  input  logic [1:0]       accType,
  output dpStatus_t        status,
  output logic [LVL_W-1:0] levelCode,
  output logic [LVL_W-1:0] targetCode,
  output logic             accGrant,
  output logic             accBusErr,
  output logic             dbgOff
);

  logic [LVL_W-1:0] levelQ;
  logic [LVL_W-1:0] targetQ;
  logic [1:0]       curRank;
  logic             restricted;
  logic             allowed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ  <= LVL2;
      targetQ <= LVL2;
    end else begin
      if (strobe.loadLevel)
        levelQ <= isLevel(nvLoadCode) ? nvLoadCode : LVL2;
      else if (strobe.commitTarget)
        levelQ <= targetQ;
      if (strobe.latchTarget)
        targetQ <= chgCode;
    end
  end

  always_comb begin
    curRank             = levelRank(levelQ);
    status.tgtValid     = isLevel(chgCode);
    status.frozen       = (levelQ == LVL2);
    status.lowering     = levelRank(chgCode) < curRank;
    status.fullErase    = (chgCode == LVL0);
    status.partialErase = (chgCode == LVL05);
    restricted          = curRank >= 2'd2;
    allowed             = !strobe.blockAccess && (accType != TYPE_RSVD) &&
                          (!restricted || (!accDebug && bootSrc == BOOT_FLASH));
  end

  assign accGrant   = accValid && allowed;
  assign accBusErr  = accValid && !allowed;
  assign levelCode  = levelQ;
  assign targetCode = targetQ;
  assign dbgOff     = (levelQ == LVL2);

endmodule

// File: rtl/rdp_control.sv
module rdp_control
  import rdp_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               nvLoadValid,
  input  logic               chgReq,
  input  dpStatus_t          status,
  input  logic               eraseFlashAck,
  input  logic               eraseSramAck,
  input  logic               eraseBkpAck,
  input  logic               nvWrAck,
  output ctrlStrobe_t        strobe,
  output logic [ERASE_N-1:0] erasePend,
  output logic               nvWrReq,
  output logic               chgDone,
  output logic               chgErr,
  output logic               loadPhase
);

  ctrlState_t         state;
  logic               regress;
  logic [ERASE_N-1:0] ackVec;
  logic [ERASE_N-1:0] pendNext;
  logic               accept;

  always_comb begin
    ackVec          = '0;
    ackVec[ER_FULL] = eraseFlashAck;
    ackVec[ER_NS]   = eraseFlashAck;
    ackVec[ER_SRAM] = eraseSramAck;
    ackVec[ER_BKP]  = eraseBkpAck;
    pendNext        = erasePend & ~ackVec;
    accept          = (state == ST_IDLE) && chgReq && status.tgtValid && !status.frozen;

    strobe.loadLevel    = (state == ST_LOAD) && nvLoadValid;
    strobe.latchTarget  = accept;
    strobe.commitTarget = (state == ST_WRITE) && nvWrAck;
    strobe.blockAccess  = (state == ST_ERASE) || ((state == ST_WRITE) && regress);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_LOAD;
      regress   <= 1'b0;
      erasePend <= '0;
      chgDone   <= 1'b0;
      chgErr    <= 1'b0;
    end else begin
      chgDone <= 1'b0;
      chgErr  <= chgReq && !accept;
      case (state)
        ST_LOAD: if (nvLoadValid) state <= ST_IDLE;
        ST_IDLE: begin
          if (accept) begin
            regress <= status.lowering;
            if (status.lowering) begin
              erasePend[ER_FULL] <= status.fullErase;
              erasePend[ER_NS]   <= status.partialErase;
              erasePend[ER_SRAM] <= status.fullErase;
              erasePend[ER_BKP]  <= status.fullErase;
              state              <= ST_ERASE;
            end else begin
              state <= ST_WRITE;
            end
          end
        end
        ST_ERASE: begin
          erasePend <= pendNext;
          if (pendNext == '0) state <= ST_WRITE;
        end
        ST_WRITE: begin
          if (nvWrAck) begin
            chgDone <= 1'b1;
            regress <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  assign nvWrReq   = (state == ST_WRITE);
  assign loadPhase = (state == ST_LOAD);

endmodule

// File: rtl/rdp_ctrl.sv
module rdp_ctrl
  import rdp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             nvLoadValid,
  input  logic [LVL_W-1:0] nvLoadCode,
  output logic             nvWrReq,
  output logic [LVL_W-1:0] nvWrCode,
  input  logic             nvWrAck,
  input  logic             chgReq,
  input  logic [LVL_W-1:0] chgCode,
  output logic             chgDone,
  output logic             chgErr,
  input  logic [1:0]       bootSrc,
  input  logic             accValid,
  input  logic             accDebug,
  input  logic [1:0]       accType,
  output logic             accGrant,
  output logic             accBusErr,
  output logic             eraseFlashFull,
  output logic             eraseFlashNs,
  output logic             eraseSram,
  output logic             eraseBkp,
  input  logic             eraseFlashAck,
  input  logic             eraseSramAck,
  input  logic             eraseBkpAck,
  output logic [LVL_W-1:0] levelCode,
  output logic             jtagOff,
  output logic             traceViewOff,
  output logic             instrTraceOff,
  output logic             bscanOff
);

  ctrlStrobe_t        strobe;
  dpStatus_t          status;
  logic [ERASE_N-1:0] erasePend;
  logic               loadPhase;
  logic               dbgOff;

  rdp_control u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .nvLoadValid   (nvLoadValid),
    .chgReq        (chgReq),
    .status        (status),
    .eraseFlashAck (eraseFlashAck),
    .eraseSramAck  (eraseSramAck),
    .eraseBkpAck   (eraseBkpAck),
    .nvWrAck       (nvWrAck),
    .strobe        (strobe),
    .erasePend     (erasePend),
    .nvWrReq       (nvWrReq),
    .chgDone       (chgDone),
    .chgErr        (chgErr),
    .loadPhase     (loadPhase)
  );

  rdp_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .nvLoadCode (nvLoadCode),
    .chgCode    (chgCode),
    .bootSrc    (bootSrc),
    .accValid   (accValid),
    .accDebug   (accDebug),
    .accType    (accType),
    .status     (status),
    .levelCode  (levelCode),
    .targetCode (nvWrCode),
    .accGrant   (accGrant),
    .accBusErr  (accBusErr),
    .dbgOff     (dbgOff)
  );

  assign eraseFlashFull = erasePend[ER_FULL];
  assign eraseFlashNs   = erasePend[ER_NS];
  assign eraseSram      = erasePend[ER_SRAM];
  assign eraseBkp       = erasePend[ER_BKP];
  assign jtagOff        = dbgOff;
  assign traceViewOff   = dbgOff;
  assign instrTraceOff  = dbgOff;
  assign bscanOff       = dbgOff;

endmodule

// File: rtl/rdp_ctrl_checker.sv
module rdp_ctrl_checker
  import rdp_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [LVL_W-1:0] levelCode,
  input logic             jtagOff,
  input logic             accValid,
  input logic             accDebug,
  input logic [1:0]       bootSrc,
  input logic             accGrant,
  input logic             accBusErr,
  input logic             eraseFlashFull,
  input logic             eraseFlashNs,
  input logic             eraseSram,
  input logic             eraseBkp,
  input logic             nvWrReq,
  input logic             chgDone,
  input logic             chgErr,
  input logic             loadPhase
);

  logic anyErase;
  assign anyErase = eraseFlashFull || eraseFlashNs || eraseSram || eraseBkp;

  p_valid_code_r1: assert property (@(posedge clk) disable iff (!rstN)
    isLevel(levelCode));

  p_frozen_top_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!loadPhase && levelCode == LVL2) |=> (levelCode == LVL2));

  p_debug_refused_r6: assert property (@(posedge clk) disable iff (!rstN)
    (jtagOff && accValid && accDebug) |-> accBusErr);

  p_restricted_r4: assert property (@(posedge clk) disable iff (!rstN)
    (levelRank(levelCode) >= 2'd2 && accValid && (accDebug || bootSrc != BOOT_FLASH))
      |-> accBusErr);

  p_block_during_erase_r12: assert property (@(posedge clk) disable iff (!rstN)
    (anyErase && accValid) |-> accBusErr);

  p_erase_kinds_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(eraseFlashFull && eraseFlashNs));

  p_write_after_erase_r12: assert property (@(posedge clk) disable iff (!rstN)
    nvWrReq |-> !anyErase);

  p_commit_point_r12: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(levelCode) |-> (chgDone || $past(loadPhase)));

  p_done_err_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(chgDone && chgErr));

  p_response_r3: assert property (@(posedge clk) disable iff (!rstN)
    (accGrant + accBusErr) == accValid);

endmodule

bind rdp_ctrl rdp_ctrl_checker u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .levelCode      (levelCode),
  .jtagOff        (jtagOff),
  .accValid       (accValid),
  .accDebug       (accDebug),
  .bootSrc        (bootSrc),
  .accGrant       (accGrant),
  .accBusErr      (accBusErr),
  .eraseFlashFull (eraseFlashFull),
  .eraseFlashNs   (eraseFlashNs),
  .eraseSram      (eraseSram),
  .eraseBkp       (eraseBkp),
  .nvWrReq        (nvWrReq),
  .chgDone        (chgDone),
  .chgErr         (chgErr),
  .loadPhase      (loadPhase)
);

// File: tb/rdp_ctrl_test.sv
module rdp_ctrl_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       nvLoadValid = 1'b0;
  logic [7:0] nvLoadCode = 8'h00;
  logic       nvWrReq;
  logic [7:0] nvWrCode;
  logic       nvWrAck = 1'b0;
  logic       chgReq = 1'b0;
  logic [7:0] chgCode = 8'h00;
  logic       chgDone, chgErr;
  logic [1:0] bootSrc = 2'd0;
  logic       accValid = 1'b0;
  logic       accDebug = 1'b0;
  logic [1:0] accType = 2'd0;
  logic       accGrant, accBusErr;
  logic       eraseFlashFull, eraseFlashNs, eraseSram, eraseBkp;
  logic       eraseFlashAck = 1'b0, eraseSramAck = 1'b0, eraseBkpAck = 1'b0;
  logic [7:0] levelCode;
  logic       jtagOff, traceViewOff, instrTraceOff, bscanOff;

  int vectors = 0;
  int fails   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdp_ctrl uut (
    .clk(clk), .rstN(rstN), .nvLoadValid(nvLoadValid), .nvLoadCode(nvLoadCode),
    .nvWrReq(nvWrReq), .nvWrCode(nvWrCode), .nvWrAck(nvWrAck),
    .chgReq(chgReq), .chgCode(chgCode), .chgDone(chgDone), .chgErr(chgErr),
    .bootSrc(bootSrc), .accValid(accValid), .accDebug(accDebug), .accType(accType),
    .accGrant(accGrant), .accBusErr(accBusErr),
    .eraseFlashFull(eraseFlashFull), .eraseFlashNs(eraseFlashNs),
    .eraseSram(eraseSram), .eraseBkp(eraseBkp),
    .eraseFlashAck(eraseFlashAck), .eraseSramAck(eraseSramAck), .eraseBkpAck(eraseBkpAck),
    .levelCode(levelCode), .jtagOff(jtagOff), .traceViewOff(traceViewOff),
    .instrTraceOff(instrTraceOff), .bscanOff(bscanOff)
  );

  localparam logic [7:0] C0 = 8'h3C, C05 = 8'h5A, C1 = 8'hC3, C2 = 8'hA5;

  function automatic int rankOf(input logic [7:0] c);
    if (c == C0) return 0;
    if (c == C05) return 1;
    if (c == C1) return 2;
    if (c == C2) return 3;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkDbg(input string req, input bit exp);
    logic [3:0] v;
    v = {jtagOff, traceViewOff, instrTraceOff, bscanOff};
    check(v == {4{exp}}, req, v, {4{exp}});
  endtask

  // reset, check the pre-load state, then load a stored word
  task automatic loadLevel(input logic [7:0] code);
    rstN = 1'b0; nvLoadValid = 1'b0; chgReq = 1'b0; accValid = 1'b0;
    nvWrAck = 1'b0; eraseFlashAck = 1'b0; eraseSramAck = 1'b0; eraseBkpAck = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(levelCode == C2, "R2 pre-load level", levelCode, C2);
    checkDbg("R6 pre-load disables", 1'b1);
    nvLoadValid = 1'b1; nvLoadCode = code;
    @(negedge clk);
    nvLoadValid = 1'b0;
  endtask

  task automatic accessSweep(input logic [7:0] code);
    int rk;
    rk = rankOf(code);
    for (int b = 0; b < 4; b++)
      for (int d = 0; d < 2; d++)
        for (int t = 0; t < 4; t++) begin
          bit ok;
          string tag;
          @(negedge clk);
          bootSrc = 2'(b); accDebug = d[0]; accType = 2'(t); accValid = 1'b1;
          #1;
          ok = (t != 3) && (rk < 2 || (d == 0 && b == 0));
          tag = (rk < 2) ? "R3 open level" : (ok ? "R5 flash-boot user" : "R4 restricted");
          if (t == 3) tag = "R3 reserved type";
          check({accGrant, accBusErr} == {ok, !ok}, tag, {accGrant, accBusErr}, {ok, !ok});
        end
    accValid = 1'b0;
  endtask

  task automatic changeTest(input logic [7:0] start, input logic [7:0] tgt);
    int rs, rt;
    bit expErr, regress;
    logic [3:0] expErase, seen;
    bit gotDone, gotErr, fin;
    logic [7:0] expLevel;
    rs = rankOf(start); rt = rankOf(tgt);
    loadLevel(start);
    expErr   = (rt < 0) || (rs == 3);
    regress  = !expErr && (rt < rs);
    expErase = 4'b0000;
    if (regress && tgt == C0) expErase = 4'b1011;
    if (regress && tgt == C05) expErase = 4'b0100;
    expLevel = expErr ? start : tgt;
    seen = 4'b0; gotDone = 0; gotErr = 0; fin = 0;
    bootSrc = 2'd0; accDebug = 1'b0; accType = 2'd0; accValid = 1'b1;
    chgReq = 1'b1; chgCode = tgt;
    @(negedge clk);
    chgReq = 1'b0;
    for (int i = 0; i < 30 && !fin; i++) begin
      logic [3:0] er;
      er = {eraseFlashFull, eraseFlashNs, eraseSram, eraseBkp};
      seen |= er;
      gotDone |= chgDone; gotErr |= chgErr;
      fin = chgDone || chgErr;
      if (regress && (er != 0 || nvWrReq)) begin
        check(accBusErr == 1'b1, "R12 access blocked in regression", accBusErr, 1);
        check(levelCode == start, "R12 level held before commit", levelCode, start);
      end
      if (nvWrReq)
        check(nvWrCode == tgt, "R11 write code", nvWrCode, tgt);
      eraseFlashAck = er[3] | er[2];
      eraseSramAck  = er[1];
      eraseBkpAck   = er[0];
      nvWrAck       = nvWrReq;
      @(negedge clk);
    end
    eraseFlashAck = 0; eraseSramAck = 0; eraseBkpAck = 0; nvWrAck = 0; accValid = 0;
    check(fin, "R12 change finished", fin, 1);
    if (rs == 3)
      check(gotErr && !gotDone, "R7 frozen top refused", {gotErr, gotDone}, 2'b10);
    else
      check(gotErr == expErr && gotDone == !expErr, "R8 accept/refuse",
            {gotErr, gotDone}, {expErr, !expErr});
    check(seen == expErase, expErase == 4'b1011 ? "R9 full erase set" :
          (expErase == 4'b0100 ? "R10 partial erase" : "R11 no erase"), seen, expErase);
    check(levelCode == expLevel, "R1 final level", levelCode, expLevel);
    checkDbg("R6 disables after change", expLevel == C2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [7:0] codes [5];
    codes[0] = C0; codes[1] = C05; codes[2] = C1; codes[3] = C2; codes[4] = 8'h3D;

    // R2: every possible stored word
    for (int w = 0; w < 256; w++) begin
      logic [7:0] exp;
      loadLevel(8'(w));
      exp = (rankOf(8'(w)) >= 0) ? 8'(w) : C2;
      check(levelCode == exp, "R2 loaded level", levelCode, exp);
      checkDbg("R6 disables follow level", exp == C2);
    end

    // R3/R4/R5: access rules at each level
    for (int l = 0; l < 4; l++) begin
      loadLevel(codes[l]);
      accessSweep(codes[l]);
    end

    // R7..R12: every start level against every target, plus one invalid target
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 5; t++)
        changeTest(codes[s], codes[t]);

    // R8: a second request during a regression is refused
    loadLevel(C1);
    chgReq = 1'b1; chgCode = C0;
    @(negedge clk);
    chgCode = C2;
    @(negedge clk);
    chgReq = 1'b0;
    check(chgErr == 1'b1, "R8 busy request refused", chgErr, 1);
    check(eraseFlashFull == 1'b1, "R9 erase held without ack", eraseFlashFull, 1);
    eraseFlashAck = 1'b1;
    @(negedge clk);
    eraseFlashAck = 1'b0;
    check({eraseFlashFull, eraseSram, eraseBkp} == 3'b011, "R9 per-erase ack",
          {eraseFlashFull, eraseSram, eraseBkp}, 3'b011);
    check(nvWrReq == 1'b0, "R12 no write while erasing", nvWrReq, 0);
    eraseSramAck = 1'b1; eraseBkpAck = 1'b1;
    @(negedge clk);
    eraseSramAck = 1'b0; eraseBkpAck = 1'b0;
    check(nvWrReq == 1'b1 && nvWrCode == C0, "R12 write after erases", nvWrCode, C0);
    check(levelCode == C1, "R12 level not yet committed", levelCode, C1);
    nvWrAck = 1'b1;
    @(negedge clk);
    nvWrAck = 1'b0;
    check(chgDone == 1'b1 && levelCode == C0, "R12 commit with done", levelCode, C0);
    @(negedge clk);
    check(chgDone == 1'b0, "R12 done is one cycle", chgDone, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule